// File: doc/BRIEF.md
# Ageing Vector Address Generator

This block produces RAM addresses for a sliding window of N samples without ever moving stored data. The storage slot that holds the oldest sample is reused for each new sample, and every vector index is mapped to its physical slot through a rotation offset. The rotation advances by one at the start of every iteration. After that single write, the block plays back a programmable sequence of read steps. Each step names one or two vector indices to be read in the same cycle.

Each generated address is looked up in a programmable bank map, and the bank of each read is output with its address. The mapping from index to slot rotates from one iteration to the next. Two indices that were read together without trouble in one iteration can therefore fall into the same bank in a later one. The block flags this case in the same cycle as the address pair. The datapath and the RAM are outside the block.

In the vector, index 0 is the oldest sample and index N-1 is the newest. The ageing factor is one sample per iteration.

Top module: `ageing_addr_gen`

## Requirements
- R1: After reset the rotation is 0, so the first iteration writes address 0. Before any iteration starts, busy, wr_en, rd_en_a, rd_en_b and conflict are all low.
- R2: A cycle with iter_start high while busy is low causes exactly one write in the next cycle. In that cycle wr_en is high for one cycle, and wr_addr is the slot that held the oldest sample (index 0) under the previous rotation.
- R3: Each iteration advances the rotation by one, modulo N. The write addresses of successive iterations therefore step by +1 mod N and repeat after N iterations.
- R4: Read steps start in the cycle after the write, one step per cycle, in table order from step 0. For a valid step, rd_en_a is high and rd_addr_a = (idx_a + rotation) mod N, using the rotation after the advance.
- R5: A valid step with its pair bit set also drives rd_en_b high, with rd_addr_b = (idx_b + rotation) mod N in the same cycle. A valid step with the pair bit clear keeps rd_en_b low.
- R6: An iteration ends at the first step whose valid bit is clear, which then issues no read, or after the last table step. busy is low in the cycle that shows the final step, and no read follows it.
- R7: rd_bank_a and rd_bank_b equal the bank map entry of rd_addr_a and rd_addr_b. Each entry is a 2-bit bank number by default.
- R8: conflict is high exactly in a cycle where both reads are enabled and their banks are equal.
- R9: iter_start is ignored while busy is high. No write and no restart follow from it.
- R10: The new sample lives at wr_addr, which is the address of index N-1 in that iteration. A sample keeps its slot as it ages, so index j in one iteration has the same address as index j+1 had in the previous iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iter_start | input | 1 | Strobe that begins one iteration |
| seq_wr_en | input | 1 | Write one entry of the step table |
| seq_wr_step | input | PTR_W | Step number to write |
| seq_wr_valid | input | 1 | Step valid bit |
| seq_wr_pair | input | 1 | Step issues a second concurrent read |
| seq_wr_idx_a | input | ADDR_W | Vector index for the first read |
| seq_wr_idx_b | input | ADDR_W | Vector index for the second read |
| bank_wr_en | input | 1 | Write one bank map entry |
| bank_wr_addr | input | ADDR_W | Slot address to map |
| bank_wr_sel | input | BANK_W | Bank number for that slot |
| busy | output | 1 | Iteration in progress |
| wr_en | output | 1 | New-sample write strobe |
| wr_addr | output | ADDR_W | Slot for the new sample |
| rd_en_a | output | 1 | First read enable |
| rd_addr_a | output | ADDR_W | First read address |
| rd_bank_a | output | BANK_W | Bank of first read |
| rd_en_b | output | 1 | Second read enable |
| rd_addr_b | output | ADDR_W | Second read address |
| rd_bank_b | output | BANK_W | Bank of second read |
| conflict | output | 1 | Both reads target one bank |

## Verification
The assertions assume that the step table and the bank map are written only while busy is low, and that iter_start is a level that the block samples on each edge. The bench reprograms the tables only between iterations. It drives every input at the falling edge, and it raises iter_start during busy only on purpose, to test that the strobe is ignored. Index fields and bank numbers are drawn from $urandom within N and within the bank count.

// File: rtl/aag_pkg.sv
package aag_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } aag_state_e;

    localparam int unsigned AAG_PORTS = 2;

endpackage

// File: rtl/aag_mod_add.sv
module aag_mod_add #(
    parameter int unsigned N_SAMP = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] op_a,
    input  logic [ADDR_W-1:0] op_b,
    output logic [ADDR_W-1:0] sum
);
    localparam logic [ADDR_W:0] MODV = (ADDR_W+1)'(N_SAMP);

    logic [ADDR_W:0] raw;
    logic [ADDR_W:0] fix;

    // Both operands are below N, so one compare-and-subtract suffices.
    always_comb begin
        raw = {1'b0, op_a} + {1'b0, op_b};
        fix = (raw >= MODV) ? (raw - MODV) : raw;
        sum = fix[ADDR_W-1:0];
    end
endmodule

// File: rtl/aag_seq_table.sv
module aag_seq_table #(
    parameter int unsigned N_SAMP    = 16,
    parameter int unsigned SEQ_DEPTH = 16,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned PTR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_step,
    input  logic              wr_valid,
    input  logic              wr_pair,
    input  logic [ADDR_W-1:0] wr_idx_a,
    input  logic [ADDR_W-1:0] wr_idx_b,
    input  logic [PTR_W-1:0]  rd_step,
    output logic              rd_valid,
    output logic              rd_pair,
    output logic [ADDR_W-1:0] rd_idx_a,
    output logic [ADDR_W-1:0] rd_idx_b
);
    localparam logic [ADDR_W:0] MODV = (ADDR_W+1)'(N_SAMP);

    logic [SEQ_DEPTH-1:0]             val_q,  val_d;
    logic [SEQ_DEPTH-1:0]             pair_q, pair_d;
    logic [SEQ_DEPTH-1:0][ADDR_W-1:0] ia_q,   ia_d;
    logic [SEQ_DEPTH-1:0][ADDR_W-1:0] ib_q,   ib_d;
    logic [ADDR_W:0]                  na, nb;

    always_comb begin
        val_d  = val_q;
        pair_d = pair_q;
        ia_d   = ia_q;
        ib_d   = ib_q;
        // Fold out-of-range indices back below N on entry.
        na = ({1'b0, wr_idx_a} >= MODV) ? ({1'b0, wr_idx_a} - MODV) : {1'b0, wr_idx_a};
        nb = ({1'b0, wr_idx_b} >= MODV) ? ({1'b0, wr_idx_b} - MODV) : {1'b0, wr_idx_b};
        if (wr_en && (32'(wr_step) < SEQ_DEPTH)) begin
            val_d[wr_step]  = wr_valid;
            pair_d[wr_step] = wr_pair;
            ia_d[wr_step]   = na[ADDR_W-1:0];
            ib_d[wr_step]   = nb[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            pair_q <= '0;
            ia_q   <= '0;
            ib_q   <= '0;
        end else begin
            val_q  <= val_d;
            pair_q <= pair_d;
            ia_q   <= ia_d;
            ib_q   <= ib_d;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_pair  = 1'b0;
        rd_idx_a = '0;
        rd_idx_b = '0;
        if (32'(rd_step) < SEQ_DEPTH) begin
            rd_valid = val_q[rd_step];
            rd_pair  = pair_q[rd_step];
            rd_idx_a = ia_q[rd_step];
            rd_idx_b = ib_q[rd_step];
        end
    end
endmodule

// File: rtl/aag_bank_map.sv
module aag_bank_map #(
    parameter int unsigned N_SAMP = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned N_RD   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BANK_W-1:0]            wr_sel,
    input  logic [N_RD-1:0][ADDR_W-1:0]  rd_addr,
    output logic [N_RD-1:0][BANK_W-1:0]  rd_sel
);
    logic [N_SAMP-1:0][BANK_W-1:0] map_q, map_d;

    always_comb begin
        map_d = map_q;
        if (wr_en && (32'(wr_addr) < N_SAMP)) map_d[wr_addr] = wr_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            rd_sel[p] = '0;
            if (32'(rd_addr[p]) < N_SAMP) rd_sel[p] = map_q[rd_addr[p]];
        end
    end
endmodule

// File: rtl/ageing_addr_gen.sv
module ageing_addr_gen
    import aag_pkg::*;
#(
    parameter int unsigned N_SAMP    = 16,
    parameter int unsigned SEQ_DEPTH = 16,
    parameter int unsigned N_BANKS   = 4,
    localparam int unsigned ADDR_W   = (N_SAMP  > 1) ? $clog2(N_SAMP)    : 1,
    localparam int unsigned PTR_W    = (SEQ_DEPTH > 1) ? $clog2(SEQ_DEPTH) : 1,
    localparam int unsigned BANK_W   = (N_BANKS > 1) ? $clog2(N_BANKS)   : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iter_start,
    input  logic              seq_wr_en,
    input  logic [PTR_W-1:0]  seq_wr_step,
    input  logic              seq_wr_valid,
    input  logic              seq_wr_pair,
    input  logic [ADDR_W-1:0] seq_wr_idx_a,
    input  logic [ADDR_W-1:0] seq_wr_idx_b,
    input  logic              bank_wr_en,
    input  logic [ADDR_W-1:0] bank_wr_addr,
    input  logic [BANK_W-1:0] bank_wr_sel,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_en_a,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [BANK_W-1:0] rd_bank_a,
    output logic              rd_en_b,
    output logic [ADDR_W-1:0] rd_addr_b,
    output logic [BANK_W-1:0] rd_bank_b,
    output logic              conflict
);
    localparam logic [PTR_W-1:0] LAST_STEP = PTR_W'(SEQ_DEPTH - 1);

    typedef struct packed {
        aag_state_e                           state;
        logic [ADDR_W-1:0]                    rot;
        logic [PTR_W-1:0]                     step;
        logic                                 wr_en;
        logic [ADDR_W-1:0]                    wr_addr;
        logic [AAG_PORTS-1:0]                 rd_en;
        logic [AAG_PORTS-1:0][ADDR_W-1:0]     rd_addr;
        logic [AAG_PORTS-1:0][BANK_W-1:0]     rd_bank;
        logic                                 conflict;
    } gen_regs_t;

    gen_regs_t r_q, r_d;

    logic                                step_valid, step_pair;
    logic [AAG_PORTS-1:0][ADDR_W-1:0]    step_idx;
    logic [AAG_PORTS-1:0][ADDR_W-1:0]    phys_addr;
    logic [AAG_PORTS-1:0][BANK_W-1:0]    phys_bank;
    logic [ADDR_W-1:0]                   rot_next;

    aag_seq_table #(
        .N_SAMP(N_SAMP), .SEQ_DEPTH(SEQ_DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (seq_wr_en),
        .wr_step  (seq_wr_step),
        .wr_valid (seq_wr_valid),
        .wr_pair  (seq_wr_pair),
        .wr_idx_a (seq_wr_idx_a),
        .wr_idx_b (seq_wr_idx_b),
        .rd_step  (r_q.step),
        .rd_valid (step_valid),
        .rd_pair  (step_pair),
        .rd_idx_a (step_idx[0]),
        .rd_idx_b (step_idx[1])
    );

    // Rotation advance: one sample of ageing per iteration.
    aag_mod_add #(.N_SAMP(N_SAMP), .ADDR_W(ADDR_W)) u_rot_inc (
        .op_a (r_q.rot),
        .op_b (ADDR_W'(1)),
        .sum  (rot_next)
    );

    // Index to slot translation for each concurrent read port.
    for (genvar p = 0; p < AAG_PORTS; p++) begin : g_xlate
        aag_mod_add #(.N_SAMP(N_SAMP), .ADDR_W(ADDR_W)) u_xl (
            .op_a (step_idx[p]),
            .op_b (r_q.rot),
            .sum  (phys_addr[p])
        );
    end

    aag_bank_map #(
        .N_SAMP(N_SAMP), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .N_RD(AAG_PORTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .wr_addr (bank_wr_addr),
        .wr_sel  (bank_wr_sel),
        .rd_addr (phys_addr),
        .rd_sel  (phys_bank)
    );

    always_comb begin
        r_d          = r_q;
        r_d.wr_en    = 1'b0;
        r_d.rd_en    = '0;
        r_d.conflict = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (iter_start) begin
                    r_d.rot     = rot_next;
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = r_q.rot;   // slot of the oldest sample
                    r_d.step    = '0;
                    r_d.state   = ST_READ;
                end
            end
            ST_READ: begin
                if (!step_valid) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.rd_en[0]   = 1'b1;
                    r_d.rd_en[1]   = step_pair;
                    r_d.rd_addr[0] = phys_addr[0];
                    r_d.rd_bank[0] = phys_bank[0];
                    if (step_pair) begin
                        r_d.rd_addr[1] = phys_addr[1];
                        r_d.rd_bank[1] = phys_bank[1];
                    end
                    r_d.conflict = step_pair && (phys_bank[0] == phys_bank[1]);
                    if (r_q.step == LAST_STEP) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.step = r_q.step + PTR_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state == ST_READ);
    assign wr_en     = r_q.wr_en;
    assign wr_addr   = r_q.wr_addr;
    assign rd_en_a   = r_q.rd_en[0];
    assign rd_addr_a = r_q.rd_addr[0];
    assign rd_bank_a = r_q.rd_bank[0];
    assign rd_en_b   = r_q.rd_en[1];
    assign rd_addr_b = r_q.rd_addr[1];
    assign rd_bank_b = r_q.rd_bank[1];
    assign conflict  = r_q.conflict;
endmodule

// File: rtl/aag_checker.sv
module aag_checker #(
    parameter int unsigned N_SAMP = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iter_start,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en_a,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [BANK_W-1:0] rd_bank_a,
    input logic              rd_en_b,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [BANK_W-1:0] rd_bank_b,
    input logic              conflict
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_wr_q;
    logic [ADDR_W-1:0] exp_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_wr_q <= '0;
        end else if (wr_en) begin
            seen_q    <= 1'b1;
            last_wr_q <= wr_addr;
        end
    end

    always_comb begin
        exp_wr = (32'(last_wr_q) == N_SAMP - 1) ? '0 : last_wr_q + ADDR_W'(1);
    end

    p_start_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_start && !busy) |=> wr_en);

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_wr_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q) |-> (wr_addr == exp_wr));

    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_a |-> (32'(rd_addr_a) < N_SAMP)) and (rd_en_b |-> (32'(rd_addr_b) < N_SAMP)));

    p_pair_needs_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_b |-> rd_en_a);

    p_read_in_iter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_a |-> $past(busy));

    p_conflict_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (rd_en_a && rd_en_b && (rd_bank_a == rd_bank_b)));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_start && busy) |=> !wr_en);
endmodule

bind ageing_addr_gen aag_checker #(
    .N_SAMP(N_SAMP), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_aag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .iter_start (iter_start),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en_a    (rd_en_a),
    .rd_addr_a  (rd_addr_a),
    .rd_bank_a  (rd_bank_a),
    .rd_en_b    (rd_en_b),
    .rd_addr_b  (rd_addr_b),
    .rd_bank_b  (rd_bank_b),
    .conflict   (conflict)
);

// File: tb/tb_ageing_addr_gen.sv
`timescale 1ns/1ps
module tb_ageing_addr_gen;
    localparam int N  = 16;
    localparam int D  = 16;
    localparam int NB = 4;
    localparam int AW = 4;
    localparam int PW = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iter_start = 1'b0;
    logic          seq_wr_en = 1'b0;
    logic [PW-1:0] seq_wr_step = '0;
    logic          seq_wr_valid = 1'b0;
    logic          seq_wr_pair = 1'b0;
    logic [AW-1:0] seq_wr_idx_a = '0;
    logic [AW-1:0] seq_wr_idx_b = '0;
    logic          bank_wr_en = 1'b0;
    logic [AW-1:0] bank_wr_addr = '0;
    logic [BW-1:0] bank_wr_sel = '0;
    logic          busy, wr_en, rd_en_a, rd_en_b, conflict;
    logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b;
    logic [BW-1:0] rd_bank_a, rd_bank_b;

    always #10 clk = ~clk;

    ageing_addr_gen #(.N_SAMP(N), .SEQ_DEPTH(D), .N_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .iter_start(iter_start),
        .seq_wr_en(seq_wr_en), .seq_wr_step(seq_wr_step), .seq_wr_valid(seq_wr_valid),
        .seq_wr_pair(seq_wr_pair), .seq_wr_idx_a(seq_wr_idx_a), .seq_wr_idx_b(seq_wr_idx_b),
        .bank_wr_en(bank_wr_en), .bank_wr_addr(bank_wr_addr), .bank_wr_sel(bank_wr_sel),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_bank_a(rd_bank_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_bank_b(rd_bank_b),
        .conflict(conflict)
    );

    int checks = 0;
    int errors = 0;
    bit m_val[D];
    bit m_pair[D];
    int m_a[D];
    int m_b[D];
    int m_bank[N];
    int mrot = 0;
    int cap_wr = 0;
    int cap_a[D];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int phys(input int idx);
        return (idx + mrot) % N;
    endfunction

    task automatic set_step(input int s, input bit v, input bit pr, input int a, input int b);
        @(negedge clk);
        seq_wr_en = 1'b1; seq_wr_step = PW'(s); seq_wr_valid = v; seq_wr_pair = pr;
        seq_wr_idx_a = AW'(a); seq_wr_idx_b = AW'(b);
        m_val[s] = v; m_pair[s] = pr; m_a[s] = a; m_b[s] = b;
        @(negedge clk);
        seq_wr_en = 1'b0;
    endtask

    task automatic set_bank(input int ad, input int bk);
        @(negedge clk);
        bank_wr_en = 1'b1; bank_wr_addr = AW'(ad); bank_wr_sel = BW'(bk);
        m_bank[ad] = bk;
        @(negedge clk);
        bank_wr_en = 1'b0;
    endtask

    task automatic run_iter(input bit poke_busy);
        bit full;
        full = 1'b1;
        @(negedge clk); iter_start = 1'b1;
        @(negedge clk); iter_start = 1'b0;
        chk(wr_en === 1'b1 && int'(wr_addr) == mrot, "R2 write slot", int'(wr_addr), mrot);
        chk(busy === 1'b1 && rd_en_a === 1'b0, "R4 no read in write cycle", int'(rd_en_a), 0);
        cap_wr = int'(wr_addr);
        mrot = (mrot + 1) % N;
        if (poke_busy) iter_start = 1'b1;
        for (int s = 0; s < D; s++) begin
            @(negedge clk);
            iter_start = 1'b0;
            chk(wr_en === 1'b0, "R9 single write per iteration", int'(wr_en), 0);
            if (!m_val[s]) begin
                chk(rd_en_a === 1'b0 && rd_en_b === 1'b0 && busy === 1'b0,
                    "R6 end at invalid step", int'({busy, rd_en_a, rd_en_b}), 0);
                full = 1'b0;
                break;
            end
            cap_a[s] = int'(rd_addr_a);
            chk(rd_en_a === 1'b1 && int'(rd_addr_a) == phys(m_a[s]),
                "R4 read address a", int'(rd_addr_a), phys(m_a[s]));
            chk(int'(rd_bank_a) == m_bank[phys(m_a[s])], "R7 bank a",
                int'(rd_bank_a), m_bank[phys(m_a[s])]);
            if (m_pair[s]) begin
                chk(rd_en_b === 1'b1 && int'(rd_addr_b) == phys(m_b[s]),
                    "R5 read address b", int'(rd_addr_b), phys(m_b[s]));
                chk(int'(rd_bank_b) == m_bank[phys(m_b[s])], "R7 bank b",
                    int'(rd_bank_b), m_bank[phys(m_b[s])]);
                chk(conflict === (m_bank[phys(m_a[s])] == m_bank[phys(m_b[s])]),
                    "R8 conflict pair", int'(conflict),
                    int'(m_bank[phys(m_a[s])] == m_bank[phys(m_b[s])]));
            end else begin
                chk(rd_en_b === 1'b0 && conflict === 1'b0, "R5 single read",
                    int'({rd_en_b, conflict}), 0);
            end
            if (s == D - 1)
                chk(busy === 1'b0, "R6 busy low at last step", int'(busy), 0);
        end
        if (full) begin
            @(negedge clk);
            chk(rd_en_a === 1'b0 && wr_en === 1'b0, "R6 nothing after last step",
                int'({rd_en_a, wr_en}), 0);
        end
    endtask

    initial begin
        #(20ns * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int first_wr;
        int prev_wr;
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) begin m_val[i] = 0; m_pair[i] = 0; m_a[i] = 0; m_b[i] = 0; end
        for (int i = 0; i < N; i++) m_bank[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && wr_en === 1'b0 && rd_en_a === 1'b0 && rd_en_b === 1'b0
            && conflict === 1'b0, "R1 reset outputs",
            int'({busy, wr_en, rd_en_a, rd_en_b, conflict}), 0);

        // Empty table: only the write happens (R1 first slot is 0).
        run_iter(1'b0);
        chk(cap_wr == 0, "R1 first write at slot 0", cap_wr, 0);

        // R10: newest sample lives at wr_addr, oldest one above it.
        for (int i = 0; i < N; i++) set_bank(i, i % NB);
        set_step(0, 1, 0, N - 1, 0);
        set_step(1, 1, 1, 0, N - 1);
        set_step(2, 0, 0, 0, 0);
        run_iter(1'b0);
        chk(cap_a[0] == cap_wr, "R10 newest at write slot", cap_a[0], cap_wr);
        chk(cap_a[1] == (cap_wr + 1) % N, "R10 oldest next to write slot", cap_a[1], (cap_wr + 1) % N);
        prev_wr = cap_wr;
        set_step(0, 1, 0, N - 2, 0);
        run_iter(1'b1);
        chk(cap_a[0] == prev_wr, "R10 sample keeps slot while ageing", cap_a[0], prev_wr);

        // R3: write slots repeat after N iterations.
        run_iter(1'b0);
        first_wr = cap_wr;
        for (int it = 0; it < N; it++) run_iter(it % 3 == 0);
        chk(cap_wr == first_wr, "R3 wrap after N iterations", cap_wr, first_wr);

        // R8 directed: pair in different banks, then same bank after remap.
        set_step(0, 1, 1, 1, 2);
        set_step(1, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) set_bank(i, i % 2);
        run_iter(1'b0);
        for (int i = 0; i < N; i++) set_bank(i, 3);
        run_iter(1'b0);

        // Full table: every step valid, end after the last step (R6).
        for (int s = 0; s < D; s++) set_step(s, 1, s % 2, s % N, (s * 5) % N);
        run_iter(1'b1);

        // Random tables and bank maps.
        for (int round = 0; round < 30; round++) begin
            int len;
            len = int'($urandom % (D + 1));
            for (int s = 0; s < D; s++)
                set_step(s, s < len, $urandom % 2, int'($urandom % N), int'($urandom % N));
            for (int i = 0; i < N; i++) set_bank(i, int'($urandom % NB));
            run_iter($urandom % 2);
            run_iter(1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule